// File: doc/BRIEF.md
# Shared Memory Bank Conflict Resolver

This block sits in front of a banked on-chip scratch memory and schedules one access from a group of 16 parallel lanes. Each lane brings an active flag and a word address. Every address belongs to one of 16 interleaved banks, and a bank can serve only one address per cycle. The block therefore splits the group's access into as few service cycles as the bank mapping allows.

In each service cycle every bank picks one address. When several pending lanes ask for that same address, they all get it in the same cycle, as a broadcast. Lanes whose addresses differ but fall in the same bank wait for later cycles. For each cycle the block outputs the mask of lanes served, the address driven to each bank, and a flag that marks the last cycle of the access.

The controller is a two-state machine. `ST_IDLE` accepts a request. `ST_SERVE` issues one grant set per cycle. The transition `accept` (IDLE to SERVE) fires when `req_valid` is high in IDLE. The transition `finish` (SERVE to IDLE) fires in the cycle where `done` is high. The self-loop `serialize` (SERVE to SERVE) repeats while lanes are still pending after the current grant.

Top module: `smem_bank_arbiter`

## Requirements
- R1: After reset, `req_ready` is 1 and `grant_valid`, `done`, `grant_mask` and `bank_en` are all 0.
- R2: The bank of a lane is the low 4 bits of its word address (bit 0 is the least significant), so addresses that differ only above bit 3 land in the same bank.
- R3: If every active lane maps to a different bank, the access finishes in a single service cycle, and `grant_mask` equals the active mask.
- R4: If all active lanes carry one identical address, the access finishes in a single service cycle by broadcast.
- R5: The number of service cycles equals the largest count of distinct addresses among the active lanes of any one bank. Distinct addresses in one bank are therefore served in separate cycles.
- R6: In each service cycle, each bank takes the address of its lowest-numbered pending lane. The same cycle also serves every other pending lane that carries that address.
- R7: Inactive lanes are never granted and never add cycles. A request with no active lane takes exactly one service cycle with an empty `grant_mask`.
- R8: Over one access, each active lane is granted exactly once.
- R9: A request is accepted only in `ST_IDLE`, where `req_ready` is 1. `req_valid` pulses during service are ignored and do not change the grants in progress.
- R10: `done` is 1 exactly in the last service cycle of an access, and `req_ready` is 1 in the cycle that follows.
- R11: `bank_en[b]` is 1 exactly when some lane of bank b is granted in that cycle. When it is 1, bits `b*10 +: 10` of `bank_addr` hold that lane's address; otherwise they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_active | input | 16 | Per-lane active flags |
| req_addr | input | 160 | Lane i word address at bits i*10 +: 10 |
| req_ready | output | 1 | Controller is idle and accepts a request |
| grant_valid | output | 1 | A service cycle is in progress |
| grant_mask | output | 16 | Lanes served this cycle |
| bank_en | output | 16 | Banks accessed this cycle |
| bank_addr | output | 160 | Bank b address at bits b*10 +: 10 |
| done | output | 1 | Last service cycle of the current access |

## Verification
The assertions assume the request is sampled only in the accepting cycle, and that the address and active inputs may change at any other time. The bench drives random junk on `req_valid` and on the request fields during service to exercise that assumption. The assertions also assume that a lane's grant is always reported against the address latched at acceptance. The bench pairs every request with a new address set for the next one, so a stale or overwritten latch would show up. Random addresses are drawn from a small pool of upper bits per bank, which keeps same-bank conflicts and duplicate addresses frequent.

// File: rtl/smem_bank_pkg.sv
package smem_bank_pkg;
    localparam int unsigned DEF_LANES = 16;
    localparam int unsigned DEF_BANKS = 16;
    localparam int unsigned DEF_AW    = 10;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/smem_lane_store.sv
// Holds the accepted addresses and the set of lanes still waiting.
module smem_lane_store #(
    parameter int unsigned LANES = 16,
    parameter int unsigned AW    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [LANES-1:0]      load_active,
    input  logic [LANES*AW-1:0]   load_addr,
    input  logic [LANES-1:0]      retire,
    output logic [LANES-1:0]      pending,
    output logic [LANES*AW-1:0]   addr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            addr_q  <= '0;
        end else if (load) begin
            pending <= load_active;
            addr_q  <= load_addr;
        end else begin
            pending <= pending & ~retire;
        end
    end
endmodule

// File: rtl/smem_bank_pick.sv
// One bank: choose the lowest pending lane mapped here and gather all
// pending lanes that share its address.
module smem_bank_pick #(
    parameter int unsigned LANES   = 16,
    parameter int unsigned BANKS   = 16,
    parameter int unsigned AW      = 10,
    parameter int unsigned BANK_ID = 0
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*AW-1:0] addr_q,
    output logic                sel_en,
    output logic [AW-1:0]       sel_addr,
    output logic [LANES-1:0]    lane_hit
);
    localparam int unsigned BW = $clog2(BANKS);
    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    logic [AW-1:0] lane_addr [LANES];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_addr[i] = addr_q[i*AW +: AW];
        end
    end

    always_comb begin
        sel_en   = 1'b0;
        sel_addr = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!sel_en && pending[i] && lane_addr[i][BW-1:0] == MY_BANK) begin
                sel_en   = 1'b1;
                sel_addr = lane_addr[i];
            end
        end
        for (int i = 0; i < LANES; i++) begin
            lane_hit[i] = sel_en && pending[i] && (lane_addr[i] == sel_addr);
        end
    end
endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
    import smem_bank_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned BANKS = DEF_BANKS,
    parameter int unsigned AW    = DEF_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [LANES-1:0]      req_active,
    input  logic [LANES*AW-1:0]   req_addr,
    output logic                  req_ready,
    output logic                  grant_valid,
    output logic [LANES-1:0]      grant_mask,
    output logic [BANKS-1:0]      bank_en,
    output logic [BANKS*AW-1:0]   bank_addr,
    output logic                  done
);
    localparam int unsigned BW = $clog2(BANKS);

    arb_state_e state_q, state_d;

    logic                load;
    logic [LANES-1:0]    retire;
    logic [LANES-1:0]    pending;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    grant_raw;
    logic [BANKS-1:0]    pick_en;
    logic [AW-1:0]       pick_addr [BANKS];
    logic [LANES-1:0]    pick_hit  [BANKS];
    logic                last_pass;

    smem_lane_store #(.LANES(LANES), .AW(AW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_active (req_active),
        .load_addr   (req_addr),
        .retire      (retire),
        .pending     (pending),
        .addr_q      (addr_q)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        smem_bank_pick #(
            .LANES(LANES), .BANKS(BANKS), .AW(AW), .BANK_ID(b)
        ) u_pick (
            .pending  (pending),
            .addr_q   (addr_q),
            .sel_en   (pick_en[b]),
            .sel_addr (pick_addr[b]),
            .lane_hit (pick_hit[b])
        );
    end

    always_comb begin
        grant_raw = '0;
        for (int b = 0; b < BANKS; b++) begin
            grant_raw = grant_raw | pick_hit[b];
        end
        last_pass = ((pending & ~grant_raw) == '0);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        load        = 1'b0;
        retire      = '0;
        req_ready   = 1'b0;
        grant_valid = 1'b0;
        grant_mask  = '0;
        bank_en     = '0;
        bank_addr   = '0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    load    = 1'b1;
                    state_d = ST_SERVE;
                end
            end
            ST_SERVE: begin
                grant_valid = 1'b1;
                grant_mask  = grant_raw;
                retire      = grant_raw;
                bank_en     = pick_en;
                for (int b = 0; b < BANKS; b++) begin
                    bank_addr[b*AW +: AW] = pick_en[b] ? pick_addr[b] : '0;
                end
                done = last_pass;
                if (last_pass) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- assertions ----------------
    assert_grant_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((grant_mask & ~pending) == '0));

    assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && pending != '0) |-> (grant_mask != '0));

    assert_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> ((grant_mask & $past(grant_mask)) == '0));

    assert_return_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !grant_valid));

    assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !req_ready);

    assert_pending_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> (pending == ($past(pending) & ~$past(grant_mask))));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        assert_lane_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
            grant_mask[i] |->
                (bank_en[addr_q[i*AW +: BW]] &&
                 bank_addr[addr_q[i*AW +: BW]*AW +: AW] == addr_q[i*AW +: AW]));
    end
endmodule

// File: tb/test_smem_bank_arbiter.sv
module test_smem_bank_arbiter;
    localparam int  LANES = 16;
    localparam int  BANKS = 16;
    localparam int  AW    = 10;
    localparam time TCLK  = 10ns;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_valid;
    logic [LANES-1:0]    req_active;
    logic [LANES*AW-1:0] req_addr;
    logic                req_ready, grant_valid, done;
    logic [LANES-1:0]    grant_mask;
    logic [BANKS-1:0]    bank_en;
    logic [BANKS*AW-1:0] bank_addr;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [LANES-1:0] act;
    logic [AW-1:0]    ad [LANES];

    always #(TCLK/2) clk = ~clk;

    smem_bank_arbiter #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) i_smem_bank_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(req_active),
        .req_addr(req_addr), .req_ready(req_ready), .grant_valid(grant_valid),
        .grant_mask(grant_mask), .bank_en(bank_en), .bank_addr(bank_addr), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // expected cycle count: most distinct addresses in any bank, minimum one
    function automatic int exp_cycles();
        int cnt [BANKS];
        int mx = 0;
        for (int b = 0; b < BANKS; b++) cnt[b] = 0;
        for (int i = 0; i < LANES; i++) begin
            bit seen = 0;
            if (!act[i]) continue;
            for (int j = 0; j < i; j++)
                if (act[j] && ad[j] == ad[i]) seen = 1;
            if (!seen) cnt[ad[i] % BANKS]++;
        end
        for (int b = 0; b < BANKS; b++) if (cnt[b] > mx) mx = cnt[b];
        return (mx == 0) ? 1 : mx;
    endfunction

    task automatic run_req(input string tag, input bit noisy);
        logic [LANES-1:0]    pend, emask, granted;
        logic [BANKS-1:0]    een;
        logic [BANKS*AW-1:0] eaddr;
        bit                  claimed [BANKS];
        bit                  edone;
        int                  cyc, want;
        want    = exp_cycles();
        pend    = act;
        granted = '0;
        cyc     = 0;
        @(negedge clk);
        check(req_ready === 1'b1, "R9", $sformatf("%s ready before accept act=%b exp=1", tag, req_ready));
        req_valid  = 1'b1;
        req_active = act;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = ad[i];
        do begin
            @(negedge clk);
            cyc++;
            // model: walk lanes in order, first lane claims its bank's address
            emask = '0; een = '0; eaddr = '0;
            for (int b = 0; b < BANKS; b++) claimed[b] = 0;
            for (int i = 0; i < LANES; i++) begin
                int b;
                b = ad[i] % BANKS;
                if (!pend[i]) continue;
                if (!claimed[b]) begin
                    claimed[b] = 1;
                    een[b] = 1'b1;
                    eaddr[b*AW +: AW] = ad[i];
                end
                if (eaddr[b*AW +: AW] == ad[i]) emask[i] = 1'b1;
            end
            edone = ((pend & ~emask) == '0);
            check(grant_valid === 1'b1 && grant_mask === emask, "R6",
                  $sformatf("%s cyc%0d mask act=%h exp=%h", tag, cyc, grant_mask, emask));
            check(bank_en === een && bank_addr === eaddr, "R11",
                  $sformatf("%s cyc%0d banks act=%h/%h exp=%h/%h", tag, cyc, bank_en, bank_addr, een, eaddr));
            check(done === edone, "R10",
                  $sformatf("%s cyc%0d done act=%b exp=%b", tag, cyc, done, edone));
            check((grant_mask & ~act) == '0 && (grant_mask & granted) == '0, "R7",
                  $sformatf("%s cyc%0d stray grant act=%h active=%h", tag, cyc, grant_mask, act));
            granted = granted | grant_mask;
            pend = pend & ~emask;
            if (noisy) begin
                // R9: junk request while busy must be ignored
                req_valid  = 1'b1;
                req_active = LANES'($urandom);
                req_addr   = {5{$urandom}};
            end else begin
                req_valid = 1'b0;
            end
        end while (!edone && cyc < 40);
        check(cyc == want, "R5", $sformatf("%s cycles act=%0d exp=%0d", tag, cyc, want));
        check(granted === act, "R8", $sformatf("%s all served act=%h exp=%h", tag, granted, act));
        @(negedge clk);
        check(req_ready === 1'b1 && grant_valid === 1'b0, "R10",
              $sformatf("%s idle after done ready=%b gv=%b exp=1/0", tag, req_ready, grant_valid));
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_valid = 1'b0; req_active = '0; req_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready === 1'b1 && grant_valid === 1'b0 && done === 1'b0 &&
              grant_mask === '0 && bank_en === '0, "R1",
              $sformatf("reset ready=%b gv=%b done=%b mask=%h exp=1/0/0/0", req_ready, grant_valid, done, grant_mask));
        rst_n = 1'b1;

        // R3: one lane per bank, upper bits scattered
        act = '1;
        for (int i = 0; i < LANES; i++) ad[i] = AW'(((i * 7) % 64) * BANKS + ((i * 5) % BANKS));
        run_req("R3 distinct banks", 0);

        // R4: broadcast of one address
        for (int i = 0; i < LANES; i++) ad[i] = 10'h2A7;
        run_req("R4 broadcast", 0);

        // R2: same low bits, different upper bits -> 16 cycles
        for (int i = 0; i < LANES; i++) ad[i] = AW'(i * BANKS + 5);
        run_req("R2 one bank", 1);

        // R6: two addresses in bank 3, interleaved lanes
        for (int i = 0; i < LANES; i++) ad[i] = (i % 2) ? 10'h013 : 10'h103;
        run_req("R6 two addrs", 0);

        // R7: no active lane
        act = '0;
        run_req("R7 empty", 0);

        // R7: inactive lanes carry conflicting addresses
        act = 16'h00FF;
        for (int i = 0; i < LANES; i++) ad[i] = (i < 8) ? AW'(i) : AW'(BANKS * i);
        run_req("R7 masked", 1);

        for (int k = 0; k < 400; k++) begin
            int mode;
            mode = $urandom_range(0, 3);
            act = LANES'($urandom);
            for (int i = 0; i < LANES; i++) begin
                case (mode)
                    0: ad[i] = AW'($urandom);
                    1: ad[i] = AW'($urandom_range(0, 3) * BANKS + $urandom_range(0, 3));
                    2: ad[i] = AW'($urandom_range(0, 1) * BANKS * 8 + i);
                    default: ad[i] = AW'($urandom_range(0, 2) * BANKS + 9);
                endcase
            end
            run_req($sformatf("R5 rnd%0d", k), k[0]);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule